// File: doc/BRIEF.md
# Packed Word Minimum-Position Unit

This SIMD execution unit accepts a 128-bit source vector that holds eight unsigned 16-bit lanes. It returns the smallest lane value together with the number of the lane that holds it. Both are packed into the low bits of a 128-bit result, and every other result bit is cleared. On a tie, the lane with the lowest number is reported. The result goes to a destination register that may be wider than 128 bits. A mode input selects what happens to the destination bits above 128. In merge mode they keep the previous contents, which the caller supplies. In zeroing mode they are cleared.

In zeroing mode the unit also checks two encoding fields: a vector-length bit and a 4-bit extra-register field. If either is not legal, the operation is rejected. The unit then raises an undefined-instruction flag next to the result and signals no write-back. The search is a three-stage pipelined tournament tree. Operands enter through a valid/ready handshake and results leave through another. A stalled output freezes the whole pipeline.

Top module: `minpos_unit`

## Requirements
- R1: When `out_wr_en` is high, `out_dst[15:0]` holds the smallest unsigned value among the eight source lanes. Lane i occupies `in_src[16*i+15:16*i]`.
- R2: When `out_wr_en` is high, `out_dst[18:16]` holds the number of a lane whose value equals the minimum. If several lanes share the minimum, the lowest lane number is reported. In particular, a vector whose lanes are all equal, including all 0xFFFF, reports lane 0.
- R3: `out_dst[127:19]` is always zero while `out_valid` is high.
- R4: In merge mode (`in_zero_mode` = 0), `out_dst[DST_W-1:128]` equals the `in_old_upper` value that was presented with the operation. The encoding fields are not checked in this mode, so any `in_vl` and `in_xreg` give a normal write.
- R5: In zeroing mode (`in_zero_mode` = 1) with a legal encoding, `out_dst[DST_W-1:128]` is zero.
- R6: In zeroing mode, an operation is rejected if `in_vl` = 1 or if `in_xreg` is not 4'b1111. A rejected operation delivers `out_undef` = 1, `out_wr_en` = 0 and an all-zero `out_dst`. When `out_valid` is high, exactly one of `out_wr_en` and `out_undef` is high, and both are low while `out_valid` is low.
- R7: An operation accepted on a clock edge with no output stall appears on `out_valid` after the second following edge. Results leave in the order the operations were accepted.
- R8: While `out_valid` is high and `out_ready` is low, `in_ready` is low and all outputs hold their values.
- R9: After reset, `out_valid`, `out_wr_en` and `out_undef` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit can take an operation on this edge |
| in_src | input | 128 | Eight unsigned 16-bit lanes, lane 0 in the low bits |
| in_old_upper | input | DST_W-128 | Previous destination contents above bit 127 |
| in_zero_mode | input | 1 | 1 = clear upper bits and check the encoding, 0 = merge |
| in_vl | input | 1 | Vector-length encoding bit, must be 0 in zeroing mode |
| in_xreg | input | 4 | Extra-register encoding field, must be 4'b1111 in zeroing mode |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result on this edge |
| out_dst | output | DST_W | Full destination value |
| out_wr_en | output | 1 | Write `out_dst` back to the destination |
| out_undef | output | 1 | Operation rejected as undefined |

## Verification
The bench builds the unit with the default `DST_W` of 256. This gives a 128-bit upper half, so the difference between merge and zeroing modes can be seen on every bit above 127. Because each vector's old upper value carries a distinct pattern, a wrong upper-bit source or a swapped mode select shows up in the compared destination. The vectors put ties at the first, the last and interior lanes. They include values with the top bit set, to catch signed comparison, and all-equal inputs. Together these reach every compare node's tie rule.

// File: rtl/minpos_pkg.sv
`timescale 1ns/1ps
package minpos_pkg;

    localparam int LANE_W    = 16;
    localparam int NUM_LANES = 8;
    localparam int IDX_W     = $clog2(NUM_LANES);
    localparam int SRC_W     = LANE_W * NUM_LANES;
    localparam int XREG_W    = 4;
    localparam int PAD_W     = SRC_W - LANE_W - IDX_W;

    // Candidate travelling through the tournament tree.
    typedef struct packed {
        logic [LANE_W-1:0] val;
        logic [IDX_W-1:0]  idx;
    } cand_t;

    // Zeroing-mode encoding rule: vector-length bit clear, extra field all ones.
    function automatic logic enc_illegal(input logic zero_mode,
                                         input logic vl,
                                         input logic [XREG_W-1:0] xreg);
        return zero_mode & (vl | (xreg != {XREG_W{1'b1}}));
    endfunction

endpackage

// File: rtl/minpos_node.sv
`timescale 1ns/1ps
// One compare node: the right (higher-lane) side wins only when strictly smaller.
module minpos_node
    import minpos_pkg::*;
(
    input  cand_t a_i,
    input  cand_t b_i,
    output cand_t win_o
);

    always_comb begin
        if (b_i.val < a_i.val) begin
            win_o = b_i;
        end else begin
            win_o = a_i;
        end
    end

endmodule

// File: rtl/minpos_pack.sv
`timescale 1ns/1ps
// Builds the full destination word from the winning candidate.
module minpos_pack
    import minpos_pkg::*;
#(
    parameter int DST_W = 256,
    localparam int UP_W = (DST_W > SRC_W) ? (DST_W - SRC_W) : 1
) (
    input  cand_t             best_i,
    input  logic              zero_mode_i,
    input  logic              undef_i,
    input  logic [UP_W-1:0]   old_upper_i,
    output logic [DST_W-1:0]  dst_o
);

    logic [SRC_W-1:0] low_w;

    always_comb begin
        low_w = {{PAD_W{1'b0}}, best_i.idx, best_i.val};
    end

    generate
        if (DST_W > SRC_W) begin : g_wide
            logic [UP_W-1:0] upper_w;
            always_comb begin
                upper_w = zero_mode_i ? '0 : old_upper_i;
                dst_o   = undef_i ? '0 : {upper_w, low_w};
            end
        end else begin : g_narrow
            logic unused_w;
            always_comb begin
                unused_w = zero_mode_i ^ (^old_upper_i);
                dst_o    = undef_i ? '0 : low_w;
            end
        end
    endgenerate

endmodule

// File: rtl/minpos_unit.sv
`timescale 1ns/1ps
module minpos_unit
    import minpos_pkg::*;
#(
    parameter int DST_W = 256,
    localparam int UP_W = (DST_W > SRC_W) ? (DST_W - SRC_W) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [SRC_W-1:0]   in_src,
    input  logic [UP_W-1:0]    in_old_upper,
    input  logic               in_zero_mode,
    input  logic               in_vl,
    input  logic [XREG_W-1:0]  in_xreg,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [DST_W-1:0]   out_dst,
    output logic               out_wr_en,
    output logic               out_undef
);

    localparam int L1_N = NUM_LANES / 2;
    localparam int L2_N = NUM_LANES / 4;

    typedef struct packed {
        // stage 1: four survivors
        logic                  v1;
        cand_t [L1_N-1:0]      c1;
        logic [UP_W-1:0]       old1;
        logic                  zm1;
        logic                  ud1;
        // stage 2: two survivors
        logic                  v2;
        cand_t [L2_N-1:0]      c2;
        logic [UP_W-1:0]       old2;
        logic                  zm2;
        logic                  ud2;
        // stage 3: packed result
        logic                  v3;
        logic [DST_W-1:0]      dst3;
        logic                  ud3;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    cand_t [NUM_LANES-1:0] lanes_w;
    cand_t [L1_N-1:0]      l1_win_w;
    cand_t [L2_N-1:0]      l2_win_w;
    cand_t                 l3_win_w;
    logic [DST_W-1:0]      packed_w;
    logic                  advance_w;

    // Split the source into indexed candidates.
    generate
        for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
            assign lanes_w[g].val = in_src[g*LANE_W +: LANE_W];
            assign lanes_w[g].idx = IDX_W'(g);
        end

        for (genvar g = 0; g < L1_N; g++) begin : g_l1
            minpos_node u_node (
                .a_i  (lanes_w[2*g]),
                .b_i  (lanes_w[2*g+1]),
                .win_o(l1_win_w[g])
            );
        end

        for (genvar g = 0; g < L2_N; g++) begin : g_l2
            minpos_node u_node (
                .a_i  (pipe_q.c1[2*g]),
                .b_i  (pipe_q.c1[2*g+1]),
                .win_o(l2_win_w[g])
            );
        end
    endgenerate

    minpos_node u_l3 (
        .a_i  (pipe_q.c2[0]),
        .b_i  (pipe_q.c2[1]),
        .win_o(l3_win_w)
    );

    minpos_pack #(.DST_W(DST_W)) u_pack (
        .best_i     (l3_win_w),
        .zero_mode_i(pipe_q.zm2),
        .undef_i    (pipe_q.ud2),
        .old_upper_i(pipe_q.old2),
        .dst_o      (packed_w)
    );

    // Whole pipeline moves together unless the finished result is stalled.
    assign advance_w = !pipe_q.v3 || out_ready;

    always_comb begin
        pipe_d = pipe_q;
        if (advance_w) begin
            pipe_d.v1   = in_valid;
            pipe_d.c1   = l1_win_w;
            pipe_d.old1 = in_old_upper;
            pipe_d.zm1  = in_zero_mode;
            pipe_d.ud1  = enc_illegal(in_zero_mode, in_vl, in_xreg);

            pipe_d.v2   = pipe_q.v1;
            pipe_d.c2   = l2_win_w;
            pipe_d.old2 = pipe_q.old1;
            pipe_d.zm2  = pipe_q.zm1;
            pipe_d.ud2  = pipe_q.ud1;

            pipe_d.v3   = pipe_q.v2;
            pipe_d.dst3 = packed_w;
            pipe_d.ud3  = pipe_q.ud2;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign in_ready  = advance_w;
    assign out_valid = pipe_q.v3;
    assign out_dst   = pipe_q.dst3;
    assign out_undef = pipe_q.v3 & pipe_q.ud3;
    assign out_wr_en = pipe_q.v3 & ~pipe_q.ud3;

endmodule

// File: rtl/minpos_unit_chk.sv
`timescale 1ns/1ps
module minpos_unit_chk
    import minpos_pkg::*;
#(
    parameter int DST_W = 256
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DST_W-1:0]  out_dst,
    input logic              out_wr_en,
    input logic              out_undef
);

    // R3: the space between the index field and bit 127 stays clear.
    p_pad_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_dst[SRC_W-1:LANE_W+IDX_W] == '0);

    // R6: a rejected operation carries no data and no write.
    p_undef_nowrite_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_undef |-> (!out_wr_en && out_dst == '0));

    // R6: a valid result is either written or rejected, never both.
    p_one_outcome_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_wr_en != out_undef));

    // R6: no outcome flags without a result.
    p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!out_wr_en && !out_undef));

    // R8: a stalled output blocks new input.
    p_stall_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    // R8: a stalled result holds on the next cycle.
    p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_dst) && $stable(out_undef) && $stable(out_wr_en)));

endmodule

bind minpos_unit minpos_unit_chk #(.DST_W(DST_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_ready (in_ready),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_dst  (out_dst),
    .out_wr_en(out_wr_en),
    .out_undef(out_undef)
);

// File: tb/tb_minpos_unit.sv
`timescale 1ns/1ps
module tb_minpos_unit;

    localparam int DW = 256;
    localparam int UW = DW - 128;
    localparam int NV = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [127:0]  in_src = '0;
    logic [UW-1:0] in_old_upper = '0;
    logic          in_zero_mode = 1'b0;
    logic          in_vl = 1'b0;
    logic [3:0]    in_xreg = 4'hF;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [DW-1:0] out_dst;
    logic          out_wr_en;
    logic          out_undef;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    minpos_unit #(.DST_W(DW)) dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_src(in_src), .in_old_upper(in_old_upper),
        .in_zero_mode(in_zero_mode), .in_vl(in_vl), .in_xreg(in_xreg),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_dst(out_dst), .out_wr_en(out_wr_en), .out_undef(out_undef)
    );

    typedef struct packed {
        logic [127:0] src;
        logic         zm;
        logic         vl;
        logic [3:0]   xr;
        logic [15:0]  ev;
        logic [2:0]   ei;
        logic         eu;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{128'h0008_0007_0006_0005_0004_0003_0002_0001, 1'b0, 1'b0, 4'hF, 16'h0001, 3'd0, 1'b0},
        '{128'h0001_0002_0003_0004_0005_0006_0007_0008, 1'b0, 1'b0, 4'hF, 16'h0001, 3'd7, 1'b0},
        '{128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0, 4'hF, 16'hFFFF, 3'd0, 1'b0},
        '{128'h1234_1234_1234_1234_1234_1234_1234_1234, 1'b0, 1'b0, 4'hF, 16'h1234, 3'd0, 1'b0},
        '{128'h0000_9000_0000_8000_7000_6000_5000_4000, 1'b1, 1'b0, 4'hF, 16'h0000, 3'd5, 1'b0},
        '{128'h8000_0003_7FFF_0003_FFFF_0004_0005_0006, 1'b0, 1'b0, 4'hF, 16'h0003, 3'd4, 1'b0},
        '{128'h0008_0007_0006_0005_0004_0003_0002_0001, 1'b1, 1'b1, 4'hF, 16'h0000, 3'd0, 1'b1},
        '{128'h0008_0007_0006_0005_0004_0003_0002_0001, 1'b1, 1'b0, 4'hE, 16'h0000, 3'd0, 1'b1},
        '{128'h0100_0200_0300_0400_0050_0600_0700_0800, 1'b0, 1'b1, 4'h0, 16'h0050, 3'd3, 1'b0},
        '{128'hFFFE_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0, 4'hF, 16'hFFFE, 3'd7, 1'b0}
    };

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] expect_dst(input vec_t v, input logic [UW-1:0] old);
        if (v.eu) return '0;
        return {(v.zm ? {UW{1'b0}} : old), 109'h0, v.ei, v.ev};
    endfunction

    // Offer one operation starting at a negedge; return on the negedge after acceptance.
    task automatic send(input logic [127:0] src, input logic [UW-1:0] old,
                        input logic zm, input logic vl, input logic [3:0] xr);
        in_src = src; in_old_upper = old; in_zero_mode = zm; in_vl = vl; in_xreg = xr;
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wait_out(output int n);
        n = 0;
        while (!out_valid && n < 20) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        #(5.0 * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        int n;
        logic [UW-1:0] old;
        logic [DW-1:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        check("R9 out_valid after reset", DW'(out_valid), DW'(0));
        check("R9 in_ready after reset", DW'(in_ready), DW'(1));
        check("R9 flags after reset", DW'({out_wr_en, out_undef}), DW'(0));

        // Table walk: R1 R2 R3 R4 R5 R6 R7
        for (int k = 0; k < NV; k++) begin
            old = {4{32'h5A5A_0000 | 32'(k)}};
            send(VECS[k].src, old, VECS[k].zm, VECS[k].vl, VECS[k].xr);
            wait_out(n);
            check($sformatf("R7 latency vec %0d", k), DW'(n), DW'(2));
            check($sformatf("R1 R2 R3 R4 R5 R6 dst vec %0d", k), out_dst, expect_dst(VECS[k], old));
            check($sformatf("R6 flags vec %0d", k), DW'({out_wr_en, out_undef}),
                  DW'({~VECS[k].eu, VECS[k].eu}));
            @(negedge clk);
        end

        // R8: stall holds the result and blocks input; R7: order kept
        out_ready = 1'b0;
        send(128'h0010_0010_0010_0010_0010_0003_0010_0010, {UW{1'b1}}, 1'b0, 1'b0, 4'hF);
        wait_out(n);
        held = out_dst;
        check("R8 first result under stall", out_dst, {{UW{1'b1}}, 109'h0, 3'd2, 16'h0003});
        in_src = 128'h0020_0020_0020_0020_0020_0020_0020_0009;
        in_old_upper = '0; in_zero_mode = 1'b1; in_vl = 1'b0; in_xreg = 4'hF;
        in_valid = 1'b1;
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            check("R8 in_ready low while stalled", DW'(in_ready), DW'(0));
            check("R8 result held while stalled", out_dst, held);
            check("R8 out_valid held while stalled", DW'(out_valid), DW'(1));
        end
        out_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check("R8 drained after release", DW'(out_valid), DW'(0));
        wait_out(n);
        check("R7 second result latency", DW'(n), DW'(2));
        check("R7 second result in order", out_dst, {{UW{1'b0}}, 109'h0, 3'd0, 16'h0009});
        @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule